// File: doc/BRIEF.md
# Store-Pair Decode and Address Unit

This unit takes one 32-bit store-pair instruction word at a time, checks that the word is the unprivileged 64-bit store-pair form, and carries it out. It holds its own register file: 31 general registers of 64 bits plus a stack pointer at index 31. It reads two data registers and a base register, and forms the access address from the base and a scaled 7-bit signed immediate. It presents one 128-bit write request to the memory side. Once that request is accepted, it updates the base register if the indexing mode asks for it.

Instructions enter on a valid/ready stream. `in_ready` is high only while the unit is idle, so there is at most one instruction in flight. Write requests leave on a second valid/ready stream. While `mem_ready` is low the unit keeps `mem_valid` and the whole request stable, and it accepts no further instruction. An instruction that cannot execute does not issue a request. Instead it raises a one-cycle fault indication that carries exactly one cause: undefined, no-op or misaligned stack. The register load port lets the surrounding core place values in the register file.

Top module: `pair_store_unit`

## Requirements
- R1: After reset `in_ready`=1, `mem_valid`=0 and `flt_valid`=0. `in_ready` is 1 only when neither a request nor a fault is pending. While `mem_valid`=1 and `mem_ready`=0, the request fields and `mem_valid` hold their values.
- R2: A word is accepted for execution only when bits[31:30]=11, bits[29:27]=101, bit26=0, bit25=0, bit22=0 and bits[24:23] is not 00. Any other word raises an undefined fault and issues no request.
- R3: While `feat_en`=0, every word raises an undefined fault, including a word that otherwise matches.
- R4: The byte offset is the 7-bit field bits[21:15], sign-extended and multiplied by 8. This gives a range of −512 to +504.
- R5: The indexing mode is set by bits[24:23]. With 10 the address is base+offset and there is no update. With 11 the address is base+offset and the base becomes base+offset. With 01 the address is the unmodified base and the base becomes base+offset.
- R6: Base field bits[9:5]=31 selects the stack pointer. If its low 4 bits are not all zero, an alignment fault is raised and both the request and the base update are suppressed.
- R7: With `be_data`=0, `mem_data` is {second, first}: the first data register (bits[4:0]) is in `mem_data[63:0]`. With `be_data`=1 the halves are swapped.
- R8: A data register field (bits[4:0] or bits[14:10]) of 31 supplies zero.
- R9: If a mode with an update names the base (not 31) as a data register, the default policy stores that register's value from before the update.
- R10: `mem_tagchk`=1 when the mode updates the base or when the base field is not 31.
- R11: `mem_unpriv`=1 exactly when `ua_override`=0 and either `priv_lvl`=1, or `priv_lvl`=2 with `host_ext`=1 and `host_trap`=1.
- R12: Register file writes take effect on the next edge, and load index 31 writes the stack pointer. All registers reset to zero. The base update commits on the edge where `mem_ready` meets `mem_valid`.
- R13: A fault shows as `flt_valid` high for exactly one cycle, with exactly one of `flt_undef`, `flt_nop` and `flt_align` set. Priority is undefined, then no-op, then alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle, word will be taken |
| in_instr | input | 32 | Instruction word |
| feat_en | input | 1 | Store-pair form enabled |
| ua_override | input | 1 | User-access override; 1 keeps the current privilege |
| priv_lvl | input | 2 | Current privilege level |
| host_ext | input | 1 | Level-2 host extension enabled |
| host_trap | input | 1 | Level-2 general trapping enabled |
| be_data | input | 1 | Data accesses are big-endian |
| rf_wr_en | input | 1 | Register load strobe |
| rf_wr_idx | input | 5 | Register load index, 31 is the stack pointer |
| rf_wr_data | input | 64 | Register load value |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory side accepts request |
| mem_addr | output | 64 | Byte address of the 16-byte write |
| mem_data | output | 128 | Write data |
| mem_unpriv | output | 1 | Access performed with user privilege |
| mem_tagchk | output | 1 | Access subject to tag checking |
| flt_valid | output | 1 | Fault indication, one cycle |
| flt_undef | output | 1 | Undefined-instruction cause |
| flt_nop | output | 1 | No-op cause |
| flt_align | output | 1 | Stack alignment cause |

## Verification
The checker watches the stream rules on every cycle: the request stays stable under back-pressure, an idle `in_ready` never coincides with a pending request or fault, and a fault is a single pulse with one cause. It also checks the port-visible effects of decode on every cycle: a disabled feature or a wrong fixed bit leads to an undefined fault, a set override never yields an unprivileged request, and a general-register base always yields a tag-checked request. Addresses, offsets, data ordering, the zero register, the overlap policy and base updates depend on register contents, and only the bench scenarios can show them. The bench reveals each updated base through a follow-up zero-offset store. It shows that the stack pointer stays unchanged after an alignment fault by repeating the fault.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [1:0] {
    IDX_NONE = 2'b00,
    IDX_POST = 2'b01,
    IDX_OFFS = 2'b10,
    IDX_PRE  = 2'b11
  } idx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_FLT  = 2'b10
  } unit_st_e;

  typedef struct packed {
    logic      hit;
    idx_mode_e mode;
    logic [6:0] imm;
    logic [4:0] rsrc_b;
    logic [4:0] rbase;
    logic [4:0] rsrc_a;
  } pair_dec_t;

  localparam int unsigned OVL_KEEP  = 0;
  localparam int unsigned OVL_ARB   = 1;
  localparam int unsigned OVL_UNDEF = 2;
  localparam int unsigned OVL_NOP   = 3;
endpackage

// File: rtl/psu_decode.sv
module psu_decode
  import psu_pkg::*;
(
  input  logic [31:0] word,
  output pair_dec_t   dec
);
  logic fixed_ok;

  always_comb begin
    fixed_ok = (word[31:30] == 2'b11) && (word[29:27] == 3'b101) &&
               !word[26] && !word[25] && !word[22];
    dec.mode   = idx_mode_e'(word[24:23]);
    dec.hit    = fixed_ok && (word[24:23] != 2'b00);
    dec.imm    = word[21:15];
    dec.rsrc_b = word[14:10];
    dec.rbase  = word[9:5];
    dec.rsrc_a = word[4:0];
  end
endmodule

// File: rtl/psu_regfile.sv
module psu_regfile #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [RIW-1:0]  ld_idx,
  input  logic [XLEN-1:0] ld_data,
  input  logic            wb_we,
  input  logic [RIW-1:0]  wb_idx,
  input  logic [XLEN-1:0] wb_data,
  input  logic [RIW-1:0]  base_idx,
  input  logic [RIW-1:0]  a_idx,
  input  logic [RIW-1:0]  b_idx,
  output logic [XLEN-1:0] base_val,
  output logic [XLEN-1:0] a_val,
  output logic [XLEN-1:0] b_val
);
  // the top entry is the stack pointer for base use and zero for data use
  localparam logic [RIW-1:0] TOP_IDX = RIW'(NREG - 1);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (ld_we) regs[ld_idx] <= ld_data;
      if (wb_we) regs[wb_idx] <= wb_data;
    end
  end

  always_comb begin
    base_val = regs[base_idx];
    a_val    = (a_idx == TOP_IDX) ? '0 : regs[a_idx];
    b_val    = (b_idx == TOP_IDX) ? '0 : regs[b_idx];
  end
endmodule

// File: rtl/psu_agen.sv
module psu_agen
  import psu_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMMW  = 7,
  parameter int unsigned SCALE = 3
) (
  input  logic [XLEN-1:0] base,
  input  logic [IMMW-1:0] imm,
  input  idx_mode_e       mode,
  output logic [XLEN-1:0] acc_addr,
  output logic [XLEN-1:0] upd_addr,
  output logic            upd_en
);
  localparam int unsigned EXTW = XLEN - IMMW - SCALE;

  logic [XLEN-1:0] offset;

  always_comb begin
    offset   = {{EXTW{imm[IMMW-1]}}, imm, {SCALE{1'b0}}};
    upd_addr = base + offset;
    acc_addr = (mode == IDX_POST) ? base : upd_addr;
    upd_en   = (mode == IDX_POST) || (mode == IDX_PRE);
  end
endmodule

// File: rtl/psu_qual.sv
module psu_qual (
  input  logic       ua_override,
  input  logic [1:0] priv_lvl,
  input  logic       host_ext,
  input  logic       host_trap,
  input  logic       upd_en,
  input  logic       base_is_sp,
  output logic       unpriv,
  output logic       tagchk
);
  logic host_user;

  always_comb begin
    host_user = (priv_lvl == 2'd2) && host_ext && host_trap;
    unpriv    = !ua_override && ((priv_lvl == 2'd1) || host_user);
    tagchk    = upd_en || !base_is_sp;
  end
endmodule

// File: rtl/pair_store_unit.sv
module pair_store_unit
  import psu_pkg::*;
#(
  parameter int unsigned     XLEN       = 64,
  parameter int unsigned     NREG       = 32,
  parameter int unsigned     IMMW       = 7,
  parameter int unsigned     SCALE      = 3,
  parameter int unsigned     ALIGN_BITS = 4,
  parameter int unsigned     OVL_POLICY = OVL_KEEP,
  parameter logic [XLEN-1:0] ARB_FILL   = '1,
  localparam int unsigned    RIW        = $clog2(NREG),
  localparam int unsigned    DW         = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic            feat_en,
  input  logic            ua_override,
  input  logic [1:0]      priv_lvl,
  input  logic            host_ext,
  input  logic            host_trap,
  input  logic            be_data,
  input  logic            rf_wr_en,
  input  logic [RIW-1:0]  rf_wr_idx,
  input  logic [XLEN-1:0] rf_wr_data,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic [DW-1:0]   mem_data,
  output logic            mem_unpriv,
  output logic            mem_tagchk,
  output logic            flt_valid,
  output logic            flt_undef,
  output logic            flt_nop,
  output logic            flt_align
);
  localparam logic [RIW-1:0] SP_IDX = RIW'(NREG - 1);

  pair_dec_t       dec;
  logic [XLEN-1:0] base_val, a_val, b_val, st_a, st_b;
  logic [XLEN-1:0] acc_addr, upd_addr;
  logic            upd_en, unpriv, tagchk, base_is_sp;
  logic            ovl_hit, dec_undef, dec_nop, sp_misal;
  logic [DW-1:0]   pair_word;

  unit_st_e        st_q;
  logic [XLEN-1:0] addr_q, upd_q;
  logic [DW-1:0]   data_q;
  logic [RIW-1:0]  upd_idx_q;
  logic            upd_en_q, unpriv_q, tag_q;
  logic            f_undef_q, f_nop_q, f_align_q;
  logic            commit_we;

  psu_decode u_dec (
    .word (in_instr),
    .dec  (dec)
  );

  psu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_we    (rf_wr_en),
    .ld_idx   (rf_wr_idx),
    .ld_data  (rf_wr_data),
    .wb_we    (commit_we),
    .wb_idx   (upd_idx_q),
    .wb_data  (upd_q),
    .base_idx (dec.rbase),
    .a_idx    (dec.rsrc_a),
    .b_idx    (dec.rsrc_b),
    .base_val (base_val),
    .a_val    (a_val),
    .b_val    (b_val)
  );

  psu_agen #(.XLEN(XLEN), .IMMW(IMMW), .SCALE(SCALE)) u_agen (
    .base     (base_val),
    .imm      (dec.imm),
    .mode     (dec.mode),
    .acc_addr (acc_addr),
    .upd_addr (upd_addr),
    .upd_en   (upd_en)
  );

  psu_qual u_qual (
    .ua_override (ua_override),
    .priv_lvl    (priv_lvl),
    .host_ext    (host_ext),
    .host_trap   (host_trap),
    .upd_en      (upd_en),
    .base_is_sp  (base_is_sp),
    .unpriv      (unpriv),
    .tagchk      (tagchk)
  );

  // base overlap with a data register when the mode updates a general base
  always_comb begin
    base_is_sp = (dec.rbase == SP_IDX);
    ovl_hit    = upd_en && !base_is_sp &&
                 ((dec.rsrc_a == dec.rbase) || (dec.rsrc_b == dec.rbase));
  end

  generate
    if (OVL_POLICY == OVL_ARB) begin : g_ovl_arb
      assign st_a = (ovl_hit && dec.rsrc_a == dec.rbase) ? ARB_FILL : a_val;
      assign st_b = (ovl_hit && dec.rsrc_b == dec.rbase) ? ARB_FILL : b_val;
    end else begin : g_ovl_keep
      assign st_a = a_val;
      assign st_b = b_val;
    end
  endgenerate

  always_comb begin
    dec_undef = !dec.hit || !feat_en || ((OVL_POLICY == OVL_UNDEF) && ovl_hit);
    dec_nop   = (OVL_POLICY == OVL_NOP) && ovl_hit;
    sp_misal  = base_is_sp && (base_val[ALIGN_BITS-1:0] != '0);
    pair_word = be_data ? {st_a, st_b} : {st_b, st_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      upd_q     <= '0;
      upd_idx_q <= '0;
      upd_en_q  <= 1'b0;
      unpriv_q  <= 1'b0;
      tag_q     <= 1'b0;
      f_undef_q <= 1'b0;
      f_nop_q   <= 1'b0;
      f_align_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            if (dec_undef) begin
              st_q      <= ST_FLT;
              f_undef_q <= 1'b1;
            end else if (dec_nop) begin
              st_q    <= ST_FLT;
              f_nop_q <= 1'b1;
            end else if (sp_misal) begin
              st_q      <= ST_FLT;
              f_align_q <= 1'b1;
            end else begin
              st_q      <= ST_REQ;
              addr_q    <= acc_addr;
              data_q    <= pair_word;
              unpriv_q  <= unpriv;
              tag_q     <= tagchk;
              upd_en_q  <= upd_en;
              upd_q     <= upd_addr;
              upd_idx_q <= dec.rbase;
            end
          end
        end
        ST_REQ: begin
          if (mem_ready) st_q <= ST_IDLE;
        end
        ST_FLT: begin
          st_q      <= ST_IDLE;
          f_undef_q <= 1'b0;
          f_nop_q   <= 1'b0;
          f_align_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    commit_we  = (st_q == ST_REQ) && mem_ready && upd_en_q;
    in_ready   = (st_q == ST_IDLE);
    mem_valid  = (st_q == ST_REQ);
    mem_addr   = addr_q;
    mem_data   = data_q;
    mem_unpriv = unpriv_q;
    mem_tagchk = tag_q;
    flt_valid  = (st_q == ST_FLT);
    flt_undef  = f_undef_q;
    flt_nop    = f_nop_q;
    flt_align  = f_align_q;
  end
endmodule

// File: rtl/psu_chk.sv
module psu_chk #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned DW  = 2 * XLEN
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     in_instr,
  input logic            feat_en,
  input logic            ua_override,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [XLEN-1:0] mem_addr,
  input logic [DW-1:0]   mem_data,
  input logic            mem_unpriv,
  input logic            mem_tagchk,
  input logic            flt_valid,
  input logic            flt_undef,
  input logic            flt_nop,
  input logic            flt_align
);
  logic take;
  assign take = in_valid && in_ready;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)
      && $stable(mem_unpriv) && $stable(mem_tagchk));

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && (mem_valid || flt_valid)));

  assert_fixed_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[26] |=> flt_valid && flt_undef);

  assert_feat_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !feat_en |=> flt_valid && flt_undef);

  assert_tag_gpr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_instr[9:5] != 5'd31) |=> !mem_valid || mem_tagchk);

  assert_override_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take && ua_override |=> !mem_valid || !mem_unpriv);

  assert_one_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> $countones({flt_undef, flt_nop, flt_align}) == 1);

  assert_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> !flt_valid && in_ready);

  assert_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |-> !flt_undef && !flt_nop && !flt_align);
endmodule

bind pair_store_unit psu_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_instr    (in_instr),
  .feat_en     (feat_en),
  .ua_override (ua_override),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mem_unpriv  (mem_unpriv),
  .mem_tagchk  (mem_tagchk),
  .flt_valid   (flt_valid),
  .flt_undef   (flt_undef),
  .flt_nop     (flt_nop),
  .flt_align   (flt_align)
);

// File: tb/pair_store_unit_tb.sv
module pair_store_unit_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [31:0]  in_instr = '0;
  logic         feat_en = 1'b1, ua_override = 1'b1, host_ext = 1'b0, host_trap = 1'b0;
  logic [1:0]   priv_lvl = 2'd0;
  logic         be_data = 1'b0;
  logic         rf_wr_en = 1'b0;
  logic [4:0]   rf_wr_idx = '0;
  logic [63:0]  rf_wr_data = '0;
  logic         mem_valid, mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         mem_unpriv, mem_tagchk;
  logic         flt_valid, flt_undef, flt_nop, flt_align;

  int errs = 0, checks = 0;
  logic [63:0] m [32];

  always #2 clk = ~clk;

  pair_store_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .feat_en(feat_en), .ua_override(ua_override),
    .priv_lvl(priv_lvl), .host_ext(host_ext), .host_trap(host_trap),
    .be_data(be_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_unpriv(mem_unpriv),
    .mem_tagchk(mem_tagchk), .flt_valid(flt_valid), .flt_undef(flt_undef),
    .flt_nop(flt_nop), .flt_align(flt_align)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [1:0] md, input logic [6:0] im,
                                      input logic [4:0] r2, input logic [4:0] rb,
                                      input logic [4:0] r1);
    return {2'b11, 3'b101, 2'b00, md, 1'b0, im, r2, rb, r1};
  endfunction

  function automatic logic [63:0] offs(input logic [6:0] im);
    return {{54{im[6]}}, im, 3'b000};
  endfunction

  // all tasks start and end just after a falling edge
  task automatic load(input int idx, input logic [63:0] v);
    rf_wr_en = 1'b1; rf_wr_idx = 5'(idx); rf_wr_data = v;
    @(negedge clk);
    rf_wr_en = 1'b0;
    m[idx] = v;
  endtask

  task automatic send(input logic [31:0] w);
    check("R1 ready before issue", in_ready, 1);
    in_instr = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input int stall);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check("R1 held under back-pressure", {mem_valid, in_ready}, 2'b10);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic peek(input string req, input int idx, output logic [63:0] v);
    send(enc(2'b10, 7'd0, 5'd31, 5'(idx), 5'd31));
    check(req, mem_valid, 1);
    v = mem_addr;
    drain(0);
  endtask

  task automatic fault(input string req, input logic [2:0] cause);
    check(req, {flt_valid, mem_valid, flt_undef, flt_nop, flt_align}, {2'b10, cause});
    @(negedge clk);
    check("R13 single pulse", {flt_valid, in_ready}, 2'b01);
  endtask

  initial begin
    #600000;
    errs++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [63:0] v, bv, ea, eu;
    logic [6:0]  ims [6];
    logic [6:0]  im;
    int          bn;
    logic        exp_u;
    ims = '{7'd0, 7'd1, 7'd2, 7'd62, 7'd64, 7'd126};
    for (int i = 0; i < 32; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 reset state", {in_ready, mem_valid, flt_valid}, 3'b100);
    peek("R12 reset valid", 7, v);
    check("R12 register reset to zero", v, 64'd0);

    load(5, 64'hA5A5_0101_C3C3_0005);
    load(9, 64'h5A5A_0202_3C3C_0009);

    // sweep modes, offsets, base kinds and byte order
    for (int md = 1; md < 4; md++)
      for (int ii = 0; ii < 6; ii++)
        for (int bs = 0; bs < 2; bs++)
          for (int be = 0; be < 2; be++) begin
            im = ims[ii];
            bn = (bs == 1) ? 31 : 3;
            if (!(bn == 31 && im[0])) begin
              bv = (bn == 31) ? 64'h0000_0000_0002_0000 : 64'h0000_1234_0000_8000;
              load(bn, bv);
              be_data = be[0];
              send(enc(2'(md), im, 5'd9, 5'(bn), 5'd5));
              eu = bv + offs(im);
              ea = (md == 1) ? bv : eu;
              check("R5 request issued", mem_valid, 1);
              check("R4 R5 R6 access address", mem_addr, ea);
              check("R7 pair data order", mem_data,
                    be[0] ? {m[5], m[9]} : {m[9], m[5]});
              check("R10 tag flag", mem_tagchk, (md != 2) || (bn != 31));
              drain(ii % 3);
              peek("R12 peek valid", bn, v);
              check("R5 R12 base after update", v, (md == 2) ? bv : eu);
            end
          end
    be_data = 1'b0;

    // privilege qualification sweep
    load(3, 64'h1000);
    for (int c = 0; c < 32; c++) begin
      ua_override = c[0]; priv_lvl = 2'(c >> 1); host_ext = c[3]; host_trap = c[4];
      exp_u = !c[0] && ((priv_lvl == 2'd1) || (priv_lvl == 2'd2 && c[3] && c[4]));
      send(enc(2'b10, 7'd1, 5'd5, 5'd3, 5'd9));
      check("R11 unprivileged flag", {mem_valid, mem_unpriv}, {1'b1, exp_u});
      drain(0);
    end
    ua_override = 1'b1; priv_lvl = 2'd0; host_ext = 1'b0; host_trap = 1'b0;

    // zero register as data source
    send(enc(2'b10, 7'd0, 5'd5, 5'd3, 5'd31));
    check("R8 zero register data", mem_data, {m[5], 64'd0});
    drain(0);
    send(enc(2'b10, 7'd0, 5'd31, 5'd3, 5'd9));
    check("R8 zero register second", mem_data, {64'd0, m[9]});
    drain(0);

    // overlap of base and first data register with pre-index
    load(4, 64'h2000);
    load(6, 64'h6666_0000_0000_0006);
    send(enc(2'b11, 7'd2, 5'd6, 5'd4, 5'd4));
    check("R9 overlap address", mem_addr, 64'h2010);
    check("R9 overlap stores old base", mem_data, {m[6], 64'h2000});
    drain(1);
    peek("R9 peek valid", 4, v);
    check("R9 base updated after overlap", v, 64'h2010);

    // encodings that must not execute
    send(enc(2'b10, 7'd0, 5'd5, 5'd3, 5'd9) | 32'h0400_0000);
    fault("R2 bit26 set undefined", 3'b100);
    send(enc(2'b10, 7'd0, 5'd5, 5'd3, 5'd9) | 32'h0040_0000);
    fault("R2 bit22 set undefined", 3'b100);
    send(enc(2'b00, 7'd0, 5'd5, 5'd3, 5'd9));
    fault("R2 mode 00 undefined", 3'b100);
    send(enc(2'b10, 7'd0, 5'd5, 5'd3, 5'd9) ^ 32'h8000_0000);
    fault("R2 size bits undefined", 3'b100);
    feat_en = 1'b0;
    send(enc(2'b10, 7'd0, 5'd5, 5'd3, 5'd9));
    fault("R3 feature disabled undefined", 3'b100);
    feat_en = 1'b1;

    // misaligned stack pointer: no request, no update
    load(31, 64'h8008);
    send(enc(2'b11, 7'd1, 5'd9, 5'd31, 5'd5));
    fault("R6 misaligned stack fault", 3'b001);
    send(enc(2'b10, 7'd0, 5'd9, 5'd31, 5'd5));
    fault("R6 stack unchanged after fault", 3'b001);
    load(31, 64'h8010);
    peek("R6 aligned stack accepted", 31, v);
    check("R12 stack load via index 31", v, 64'h8010);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule